// File: doc/BRIEF.md
# Two-Channel Hysteretic Fan Duty Controller

This block runs two fan PWM outputs from one automatic temperature controller. Each output picks one of several 8-bit temperature samples through its own source select. It compares that sample against a single set of four thresholds shared by both outputs, and from the comparison it keeps a speed level: off, low, high or full. A level rises as soon as a threshold is met. On a falling reading the level holds until the reading drops below the threshold under the current level. This gives one band of hysteresis between neighbouring speeds.

Under automatic control the level maps to a duty. Full and off are hard-wired, and low and high are programmed per output. Under manual control the duty comes from a per-output register. The duty the generator uses is replaced only at the end of a PWM period. An 8-bit free-running counter, shared by both outputs, forms the PWM waveform. Software programs the block through a simple write port and reads it back through a combinational read port. The read port also shows the second output's threshold view as a mirror of the shared set.

Top module: `fan_duty_ctrl`

## Requirements
- R1: After reset both levels are 0, both applied duties are 0 and both PWM pins are low. Reads return these defaults: thresholds 0x20/0x30/0x40/0x50 at 0x00..0x03, modes 0, source selects 0 and 1, high duties 0xC0, low duties 0x60, manual duties 0.
- R2: Register map, byte-wide. 0x00 off threshold, 0x01 low threshold, 0x02 high threshold, 0x03 full threshold. 0x08/0x09 mode of output 0/1. 0x0A/0x0B source of output 0/1. 0x0C/0x0D high/low duty of output 0. 0x0E/0x0F high/low duty of output 1. 0x10/0x11 manual duty of output 0/1. Every writable register reads back what was written, and unmapped addresses read 0.
- R3: Addresses 0x04..0x07 read the same values as 0x00..0x03, and writes to 0x04..0x07 change nothing.
- R4: Output n compares temperature element k = its source select, which sits at bits 8k+7:8k of `temp_bus`.
- R5: Levels are encoded 0 off, 1 low, 2 high, 3 full. When the reading is at or above the low, high or full threshold, and that level exceeds the current one, the level moves to the highest threshold met. The change shows one clock after the input.
- R6: The level falls only when the reading is below the threshold beneath the current level. Below high it leaves full, below low it leaves high, and below off it leaves low. It then moves to the level those falling thresholds give. Otherwise it holds.
- R7: With mode value 2 an output is automatic. Its duty is 255 at level 3, its own high duty at level 2, its own low duty at level 1 and 0 at level 0.
- R8: Any mode value other than 2 makes the duty equal to that output's manual duty register.
- R9: The applied duty changes only on the clock edge at which the shared counter is 255. The counter is 0 after reset and counts up by one each clock.
- R10: A PWM pin is high while the counter is below the applied duty, and it is always high when the duty is 255. Over one period the pin is high for exactly `duty` clocks, or for 256 clocks at duty 255.
- R11: The two outputs are independent in mode, source, duties and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| temp_bus | input | NSRC*8 | Packed temperature samples, element k at bits 8k+7:8k |
| lvl0 | output | 2 | Current speed level of output 0 |
| lvl1 | output | 2 | Current speed level of output 1 |
| duty0 | output | 8 | Applied duty of output 0 |
| duty1 | output | 8 | Applied duty of output 1 |
| pwm0 | output | 1 | PWM pin of output 0 |
| pwm1 | output | 1 | PWM pin of output 1 |

## Verification
The level properties relate a level change to the sample and threshold values seen one edge earlier. The meaning of the speeds assumes the thresholds are kept in ascending order, and the stimulus only writes them that way. Source selects are assumed to stay below the number of inputs, which the default power-of-two input count guarantees. Temperatures and register writes change only at the falling clock edge, so every level and duty decision sees a settled value. Duty checks wait past a full period boundary before sampling.

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl #(
  parameter int NSRC = 4,
  parameter int TW = 8,
  parameter logic [TW-1:0] AUTO_MODE = 8'd2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [4:0]               wr_addr,
  input  logic [TW-1:0]            wr_data,
  input  logic [4:0]               rd_addr,
  output logic [TW-1:0]            rd_data,
  input  logic [NSRC-1:0][TW-1:0]  temp_bus,
  output logic [1:0]               lvl0,
  output logic [1:0]               lvl1,
  output logic [TW-1:0]            duty0,
  output logic [TW-1:0]            duty1,
  output logic                     pwm0,
  output logic                     pwm1
);
  localparam int SW = $clog2(NSRC);
  localparam logic [TW-1:0] DMAX = '1;

  logic [TW-1:0] thr_r [4];
  logic [TW-1:0] mode_r [2];
  logic [TW-1:0] hi_r [2];
  logic [TW-1:0] lo_r [2];
  logic [TW-1:0] man_r [2];
  logic [SW-1:0] src_r [2];
  logic [TW-1:0] cnt;

  logic [1:0][1:0]    lv_v;
  logic [1:0][TW-1:0] duty_v;
  logic [1:0][TW-1:0] tsel_v;
  logic [1:0]         pwm_v;

  wire period_end = (cnt == DMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_r[0] <= 8'h20; thr_r[1] <= 8'h30; thr_r[2] <= 8'h40; thr_r[3] <= 8'h50;
      mode_r[0] <= '0; mode_r[1] <= '0;
      hi_r[0] <= 8'hC0; hi_r[1] <= 8'hC0;
      lo_r[0] <= 8'h60; lo_r[1] <= 8'h60;
      man_r[0] <= '0; man_r[1] <= '0;
      src_r[0] <= SW'(0); src_r[1] <= SW'(1);
    end else if (wr_en) begin
      case (wr_addr)
        5'h00, 5'h01, 5'h02, 5'h03: thr_r[wr_addr[1:0]] <= wr_data;
        5'h08: mode_r[0] <= wr_data;
        5'h09: mode_r[1] <= wr_data;
        5'h0A: src_r[0]  <= wr_data[SW-1:0];
        5'h0B: src_r[1]  <= wr_data[SW-1:0];
        5'h0C: hi_r[0]   <= wr_data;
        5'h0D: lo_r[0]   <= wr_data;
        5'h0E: hi_r[1]   <= wr_data;
        5'h0F: lo_r[1]   <= wr_data;
        5'h10: man_r[0]  <= wr_data;
        5'h11: man_r[1]  <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      5'h00, 5'h01, 5'h02, 5'h03,
      5'h04, 5'h05, 5'h06, 5'h07: rd_data = thr_r[rd_addr[1:0]];
      5'h08: rd_data = mode_r[0];
      5'h09: rd_data = mode_r[1];
      5'h0A: rd_data = {{(TW-SW){1'b0}}, src_r[0]};
      5'h0B: rd_data = {{(TW-SW){1'b0}}, src_r[1]};
      5'h0C: rd_data = hi_r[0];
      5'h0D: rd_data = lo_r[0];
      5'h0E: rd_data = hi_r[1];
      5'h0F: rd_data = lo_r[1];
      5'h10: rd_data = man_r[0];
      5'h11: rd_data = man_r[1];
      default: rd_data = '0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_out
    logic [TW-1:0] t;
    logic [1:0]    up_lv, dn_lv, lv_q, lv_d;
    logic [TW-1:0] sel_duty, duty_q;

    assign t = temp_bus[src_r[g]];

    always_comb begin
      if      (t >= thr_r[3]) up_lv = 2'd3;
      else if (t >= thr_r[2]) up_lv = 2'd2;
      else if (t >= thr_r[1]) up_lv = 2'd1;
      else                    up_lv = 2'd0;
      if      (t >= thr_r[2]) dn_lv = 2'd3;
      else if (t >= thr_r[1]) dn_lv = 2'd2;
      else if (t >= thr_r[0]) dn_lv = 2'd1;
      else                    dn_lv = 2'd0;
      if      (up_lv > lv_q) lv_d = up_lv;
      else if (dn_lv < lv_q) lv_d = dn_lv;
      else                   lv_d = lv_q;
    end

    always_comb begin
      if (mode_r[g] != AUTO_MODE) sel_duty = man_r[g];
      else begin
        case (lv_q)
          2'd3:    sel_duty = DMAX;
          2'd2:    sel_duty = hi_r[g];
          2'd1:    sel_duty = lo_r[g];
          default: sel_duty = '0;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lv_q   <= 2'd0;
        duty_q <= '0;
      end else begin
        lv_q <= lv_d;
        if (period_end) duty_q <= sel_duty;
      end
    end

    assign lv_v[g]   = lv_q;
    assign duty_v[g] = duty_q;
    assign tsel_v[g] = t;
    assign pwm_v[g]  = (duty_q == DMAX) || (cnt < duty_q);
  end

  assign lvl0  = lv_v[0];
  assign lvl1  = lv_v[1];
  assign duty0 = duty_v[0];
  assign duty1 = duty_v[1];
  assign pwm0  = pwm_v[0];
  assign pwm1  = pwm_v[1];
endmodule

// File: rtl/fan_duty_ctrl_chk.sv
module fan_duty_ctrl_chk #(
  parameter int TW = 8,
  parameter logic [TW-1:0] AUTO_MODE = 8'd2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] cnt,
  input logic [TW-1:0] thr_off,
  input logic [TW-1:0] thr_full,
  input logic [TW-1:0] t0,
  input logic [TW-1:0] t1,
  input logic [TW-1:0] mode0,
  input logic [1:0]    lv0,
  input logic [1:0]    lv1,
  input logic [TW-1:0] duty0,
  input logic [TW-1:0] duty1,
  input logic          pwm0,
  input logic          pwm1
);
  localparam logic [TW-1:0] DMAX = '1;

  assert_duty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) != DMAX) |-> ($stable(duty0) && $stable(duty1)));

  assert_pwm_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (duty0 == DMAX) |-> pwm0);

  assert_pwm_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (duty1 == '0) |-> !pwm1);

  assert_rise_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lv0 == 2'd3 && $past(lv0) != 2'd3) |-> $past(t0 >= thr_full));

  assert_drop_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lv1 == 2'd0 && $past(lv1) != 2'd0) |-> $past(t1 < thr_off));

  assert_fixed_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == DMAX && $past(mode0) == AUTO_MODE && $past(lv0) == 2'd3)
      |-> (duty0 == DMAX));
endmodule

bind fan_duty_ctrl fan_duty_ctrl_chk #(.TW(TW), .AUTO_MODE(AUTO_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt),
  .thr_off(thr_r[0]), .thr_full(thr_r[3]),
  .t0(tsel_v[0]), .t1(tsel_v[1]), .mode0(mode_r[0]),
  .lv0(lvl0), .lv1(lvl1), .duty0(duty0), .duty1(duty1),
  .pwm0(pwm0), .pwm1(pwm1)
);

// File: tb/fan_duty_ctrl_bench.sv
`timescale 1ns/1ps
module fan_duty_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0][7:0] temp_bus = '0;
  logic [1:0] lvl0, lvl1;
  logic [7:0] duty0, duty1;
  logic pwm0, pwm1;

  int ntot = 0, nfail = 0, edges = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  fan_duty_ctrl u_fan_duty_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .temp_bus(temp_bus),
    .lvl0(lvl0), .lvl1(lvl1), .duty0(duty0), .duty1(duty1), .pwm0(pwm0), .pwm1(pwm1)
  );

  // {temperature, expected level} for output 0, thresholds 20/30/40/50 hex
  localparam logic [9:0] HYS_VEC [18] = '{
    {8'h10, 2'd0}, {8'h2F, 2'd0}, {8'h30, 2'd1}, {8'h3F, 2'd1},
    {8'h40, 2'd2}, {8'h50, 2'd3}, {8'hFF, 2'd3}, {8'h48, 2'd3},
    {8'h40, 2'd3}, {8'h3F, 2'd2}, {8'h30, 2'd2}, {8'h2F, 2'd1},
    {8'h20, 2'd1}, {8'h1F, 2'd0}, {8'h45, 2'd2}, {8'h10, 2'd0},
    {8'h55, 2'd3}, {8'h25, 2'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    ntot++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic count_high(output int n0, output int n1);
    n0 = 0; n1 = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      n0 += int'(pwm0);
      n1 += int'(pwm1);
    end
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    int v, h0, h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lvl0", lvl0, 0);
    chk("R1 lvl1", lvl1, 0);
    chk("R1 duty0", duty0, 0);
    chk("R1 pwm0", pwm0, 0);
    rd(5'h00, v); chk("R1 thr off", v, 8'h20);
    rd(5'h03, v); chk("R1 thr full", v, 8'h50);
    rd(5'h0B, v); chk("R1 src1", v, 1);
    rd(5'h0E, v); chk("R1 hi1", v, 8'hC0);
    rd(5'h0D, v); chk("R1 lo0", v, 8'h60);
    rd(5'h08, v); chk("R1 mode0", v, 0);

    // R5 / R6 hysteresis table on output 0 (source 0)
    foreach (HYS_VEC[i]) begin
      temp_bus[0] = HYS_VEC[i][9:2];
      @(negedge clk);
      chk($sformatf("R5/R6 step %0d", i), lvl0, int'(HYS_VEC[i][1:0]));
    end

    // R2 read-back
    wr(5'h0C, 8'hB4); rd(5'h0C, v); chk("R2 hi0", v, 8'hB4);
    wr(5'h0C, 8'hC0);
    wr(5'h11, 8'h5A); rd(5'h11, v); chk("R2 man1", v, 8'h5A);
    rd(5'h1F, v); chk("R2 unmapped", v, 0);

    // R3 mirror and read-only second view
    wr(5'h05, 8'h99);
    rd(5'h05, v); chk("R3 ro view", v, 8'h30);
    rd(5'h01, v); chk("R3 shared unchanged", v, 8'h30);
    wr(5'h01, 8'h35);
    rd(5'h05, v); chk("R3 mirror", v, 8'h35);
    wr(5'h01, 8'h30);

    // R7 automatic duties, output 0
    wr(5'h08, 8'd2);
    temp_bus[0] = 8'h60; settle();
    chk("R7 full duty", duty0, 255);
    count_high(h0, h1); chk("R10 full high count", h0, 256);
    temp_bus[0] = 8'h45; settle();
    chk("R7 hi level", lvl0, 3);
    temp_bus[0] = 8'h3A; settle();
    chk("R7 high duty", duty0, 8'hC0);
    count_high(h0, h1); chk("R10 high count", h0, 8'hC0);
    temp_bus[0] = 8'h25; settle();
    chk("R7 low duty", duty0, 8'h60);
    count_high(h0, h1); chk("R10 low count", h0, 8'h60);
    temp_bus[0] = 8'h05; settle();
    chk("R7 off duty", duty0, 0);
    count_high(h0, h1); chk("R10 off count", h0, 0);

    // R4 / R11 output 1 on source 2 with its own duties
    wr(5'h0B, 8'd2); wr(5'h09, 8'd2); wr(5'h0E, 8'hA0); wr(5'h0F, 8'h50);
    temp_bus[1] = 8'hFF;
    temp_bus[2] = 8'h33;
    settle();
    chk("R4 lvl1 from source 2", lvl1, 1);
    chk("R11 duty1 own low", duty1, 8'h50);
    chk("R11 duty0 unaffected", duty0, 0);
    temp_bus[2] = 8'h44; settle();
    chk("R11 duty1 own high", duty1, 8'hA0);
    count_high(h0, h1); chk("R10 out1 count", h1, 8'hA0);

    // R8 manual override with a non-auto mode value
    wr(5'h10, 8'h33); wr(5'h08, 8'd3);
    settle();
    chk("R8 manual duty0", duty0, 8'h33);
    chk("R8 out1 still auto", duty1, 8'hA0);

    // R9 boundary timing of a manual change
    wr(5'h10, 8'h80); settle();
    chk("R9 preload", duty0, 8'h80);
    while (edges % 256 != 5) @(negedge clk);
    wr(5'h10, 8'h77);
    chk("R9 held after write", duty0, 8'h80);
    while (edges % 256 != 255) @(negedge clk);
    chk("R9 held to period end", duty0, 8'h80);
    @(negedge clk);
    chk("R9 applied at boundary", duty0, 8'h77);

    done = 1'b1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule